// File: doc/BRIEF.md
# Quad-Channel Serial Converter Register Front End

This block holds the digital codes of a four-channel, 12-bit serial-input converter. A host sends a 16-bit word into a serial shift register: two address bits naming the channel, two bits that carry no meaning, and then a 12-bit code. The shift register does not use a free-running system clock. It steps on each rising edge of the logical OR of the active-low chip select and the serial clock, so either pin can shift data. A transfer that ends with chip select rising while the serial clock is low therefore adds one unintended bit.

Each channel keeps its code in a level-sensitive register. The address field picks one of these registers. While the active-low load strobe is low, the picked register follows the code field of the shift register. While the strobe is high, all four registers hold. An active-low asynchronous reset forces every channel to zero-scale or mid-scale, according to a select input. The reset never touches the shift register, which starts at all zeros. The analog side is not part of this block. Only the four held codes are visible.

Top module: `quad_dac_frontend`

## Requirements
- R1: A transfer has 16 bits. The first bit shifted in ends up at word bit 15. Bits 15:14 are the address, bits 13:12 are ignored, and bits 11:0 are the code, with its most significant bit sent first.
- R2: The shift register takes one bit from `sdin` on each rising edge of (`csel_n` OR `sclk`). A word shifts the same way when `sclk` toggles with `csel_n` held low, and when `csel_n` toggles with `sclk` held low.
- R3: If `csel_n` rises while `sclk` is low, the register takes exactly one extra bit. That extra bit moves the address and the code by one position.
- R4: Address 0, 1, 2 and 3 select channel 0, 1, 2 and 3. Channel k appears on `chan_code[12k+11:12k]`.
- R5: While `load_n` is low, the selected channel equals the code field of the shift register. While `load_n` is high, no channel changes, including while a word is being shifted in.
- R6: If bits are shifted while `load_n` is low, the selection follows the address field as it changes. Every channel that is selected along the way takes the code that is present at that moment.
- R7: While `arst_n` is low, every channel reads 12'h000 if `rst_mid` is 0 and 12'h800 if `rst_mid` is 1. This holds at once, with no clock edge.
- R8: Reset leaves the shift register unchanged. When reset is released with `load_n` high, every channel keeps its reset value.
- R9: With `arst_n` low, reset wins over a low `load_n` for all channels.
- R10: The shift register starts at all zeros, so a load with no prior transfer writes 12'h000 into channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csel_n | input | 1 | Chip select, active low; ORed with the serial clock to form the shift clock |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| load_n | input | 1 | Load strobe, active low; makes the selected channel transparent |
| arst_n | input | 1 | Asynchronous reset of the channel registers, active low |
| rst_mid | input | 1 | Reset value select: 0 gives zero-scale, 1 gives mid-scale |
| chan_code | output | 48 | Four 12-bit channel codes, channel k at bits 12k+11:12k |

## Verification
The hardest case to reach is the flow-through corruption. Here the load strobe stays low while bits move, so the selected channel changes under the data, and several registers pick up partial codes. The bench gets there by lowering the strobe before a transfer. Its model applies the requirement after every single shift edge, so the expected set of corrupted channels follows directly from the address bits passing through. The spurious edge is reached by ending a transfer with the serial clock parked low and then raising chip select. A word shifted only by toggling chip select exercises the other clock path.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    // Value forced into the channel registers while reset is active
    typedef enum logic {
        RST_ZERO = 1'b0,
        RST_MID  = 1'b1
    } rst_kind_e;
endpackage

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
    parameter int WORD_W = 16
) (
    input  logic              shclk,
    input  logic              arst_n,
    input  logic              sdin,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-1:0] bits;
    } shift_st_t;

    shift_st_t st_d;
    shift_st_t st_q = '0;   // power-up contents, untouched by reset

    always_comb begin
        st_d      = st_q;
        st_d.bits = {st_q.bits[WORD_W-2:0], sdin};
    end

    always_ff @(posedge shclk) begin
        st_q <= st_d;
    end

    assign word_o = st_q.bits;

    // R2: the newest bit lands in position 0
    p_shift_in_r2: assert property (@(posedge shclk) disable iff (!arst_n)
        1'b1 |=> st_q.bits[0] == $past(sdin));

    // R2: older bits move up by exactly one place
    p_shift_move_r2: assert property (@(posedge shclk) disable iff (!arst_n)
        1'b1 |=> st_q.bits[WORD_W-1:1] == $past(st_q.bits[WORD_W-2:0]));
endmodule

// File: rtl/dacfe_decode.sv
module dacfe_decode #(
    parameter int ADDR_W = 2,
    localparam int NCH   = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              load_n,
    output logic [NCH-1:0]    en
);
    for (genvar k = 0; k < NCH; k++) begin : g_en
        assign en[k] = !load_n && (addr == ADDR_W'(k));
    end
endmodule

// File: rtl/dacfe_chan_reg.sv
module dacfe_chan_reg
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              arst_n,
    input  rst_kind_e         rst_kind,
    input  logic              en,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] q
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    // Level-sensitive storage; reset overrides the gate
    always_latch begin
        if (!arst_n) begin
            q = (rst_kind == RST_MID) ? MID_CODE : '0;
        end else if (en) begin
            q = din;
        end
    end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int ADDR_W = 2,
    parameter int GAP_W  = 2,
    localparam int WORD_W = ADDR_W + GAP_W + CODE_W,
    localparam int NCH    = 1 << ADDR_W
) (
    input  logic                  csel_n,
    input  logic                  sclk,
    input  logic                  sdin,
    input  logic                  load_n,
    input  logic                  arst_n,
    input  logic                  rst_mid,
    output logic [NCH*CODE_W-1:0] chan_code
);
    logic              shclk;
    logic [WORD_W-1:0] word_q;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic [NCH-1:0]    en;
    logic [CODE_W-1:0] chan_q [NCH];
    rst_kind_e         rst_kind;

    // Either pin can produce the shifting edge
    assign shclk    = csel_n | sclk;
    assign addr     = word_q[WORD_W-1 -: ADDR_W];
    assign code     = word_q[CODE_W-1:0];
    assign rst_kind = rst_mid ? RST_MID : RST_ZERO;

    dacfe_shift #(.WORD_W(WORD_W)) u_shift (
        .shclk (shclk),
        .arst_n(arst_n),
        .sdin  (sdin),
        .word_o(word_q)
    );

    dacfe_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .load_n(load_n),
        .en    (en)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        dacfe_chan_reg #(.CODE_W(CODE_W)) u_reg (
            .arst_n  (arst_n),
            .rst_kind(rst_kind),
            .en      (en[k]),
            .din     (code),
            .q       (chan_q[k])
        );
        assign chan_code[k*CODE_W +: CODE_W] = chan_q[k];
    end

    // R4: never more than one channel gate open
    p_sel_onehot_r4: assert property (@(posedge shclk) disable iff (!arst_n)
        $onehot0(en));

    // R5: with the strobe low the addressed channel shows the shifted code
    p_transparent_r5: assert property (@(posedge shclk) disable iff (!arst_n)
        !load_n |-> chan_q[addr] == code);
endmodule

// File: tb/quad_dac_frontend_tb.sv
module quad_dac_frontend_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;

    logic        csel_n, sclk, sdin, load_n, arst_n, rst_mid;
    logic [47:0] chan_code;

    quad_dac_frontend dut_i (
        .csel_n   (csel_n),
        .sclk     (sclk),
        .sdin     (sdin),
        .load_n   (load_n),
        .arst_n   (arst_n),
        .rst_mid  (rst_mid),
        .chan_code(chan_code)
    );

    int          n_cmp  = 0;
    int          n_fail = 0;
    logic [15:0] m_sreg = '0;
    logic [11:0] m_chan [4];

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    task automatic check(input string tag);
        #1;
        for (int k = 0; k < 4; k++) begin
            n_cmp++;
            if (chan_code[k*12 +: 12] !== m_chan[k]) begin
                n_fail++;
                $display("FAIL %s ch%0d actual=%03h expected=%03h",
                         tag, k, chan_code[k*12 +: 12], m_chan[k]);
            end
        end
    endtask

    // model of one shift edge (R2, R6)
    task automatic mshift(input logic b);
        m_sreg = {m_sreg[14:0], b};
        if (!load_n && arst_n) m_chan[m_sreg[15:14]] = m_sreg[11:0];
    endtask

    task automatic mreset(input logic mid);
        for (int k = 0; k < 4; k++) m_chan[k] = mid ? 12'h800 : 12'h000;
    endtask

    // sclk-driven bit; sclk idles high
    task automatic bit_clk(input logic b);
        sclk = 1'b0; sdin = b; #HALF;
        sclk = 1'b1; mshift(b); #HALF;
    endtask

    task automatic send_word(input logic [15:0] w);
        csel_n = 1'b0; #HALF;
        for (int i = 15; i >= 0; i--) bit_clk(w[i]);
        csel_n = 1'b1; #HALF;  // sclk high: no extra edge
    endtask

    // csel_n-driven word with sclk parked low
    task automatic send_word_cs(input logic [15:0] w);
        sclk = 1'b0; #HALF;
        for (int i = 15; i >= 0; i--) begin
            sdin = w[i]; csel_n = 1'b0; #HALF;
            csel_n = 1'b1; mshift(w[i]); #HALF;
        end
        sclk = 1'b1; #HALF;
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        if (arst_n) m_chan[m_sreg[15:14]] = m_sreg[11:0];
        #HALF; load_n = 1'b1; #HALF;
    endtask

    task automatic do_reset(input logic mid);
        rst_mid = mid; #1;
        arst_n = 1'b0; mreset(mid); #HALF;
        arst_n = 1'b1; #HALF;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL all: watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [11:0] c;
        csel_n = 1'b1; sclk = 1'b1; sdin = 1'b0; load_n = 1'b1;
        rst_mid = 1'b0; arst_n = 1'b0; mreset(1'b0);
        #CLK_PERIOD;
        check("R7 reset zero-scale");
        rst_mid = 1'b1; mreset(1'b1); #HALF;
        check("R7 reset mid-scale");
        arst_n = 1'b1; #HALF;
        check("R8 latched keep reset value");

        // R10: power-up shift contents are zero -> channel 0 gets 000
        pulse_load();
        check("R10 power-up shift zeros");

        // R1 R4 R5: sweep of every channel with varied codes and gap bits
        for (int ch = 0; ch < 4; ch++) begin
            for (int v = 0; v < 16; v++) begin
                c = 12'((v * 12'h111 + ch * 12'h0F3) & 12'hFFF);
                w = {2'(ch), 2'(v), c};
                send_word(w);
                check("R5 hold while load high");
                pulse_load();
                check("R1 R4 load addressed channel");
            end
        end

        // R2: shift with csel_n alone
        send_word_cs({2'd2, 2'b11, 12'h5A3});
        pulse_load();
        check("R2 csel_n-driven shift");

        // R3: spurious edge when csel_n rises with sclk low
        csel_n = 1'b0; #HALF;
        w = {2'd0, 2'b00, 12'hC35};
        for (int i = 15; i >= 0; i--) bit_clk(w[i]);
        sclk = 1'b0; sdin = 1'b1; #HALF;
        csel_n = 1'b1; mshift(1'b1); #HALF;
        sclk = 1'b1; #HALF;
        pulse_load();
        check("R3 extra bit shifts word");

        // R6: flow-through with load_n held low
        load_n = 1'b0;
        m_chan[m_sreg[15:14]] = m_sreg[11:0];
        #HALF;
        send_word({2'd3, 2'b01, 12'h9E7});
        send_word({2'd1, 2'b10, 12'h0F0});
        load_n = 1'b1; #HALF;
        check("R6 flow-through corruption");

        // R9: reset overrides a low load strobe
        send_word({2'd2, 2'b00, 12'h777});
        load_n = 1'b0; arst_n = 1'b0; rst_mid = 1'b0; mreset(1'b0); #HALF;
        check("R9 reset wins over load");
        arst_n = 1'b1; m_chan[2] = 12'h777; #HALF;
        check("R9 transparent after release");
        load_n = 1'b1; #HALF;

        // R8: reset leaves the shift register untouched
        send_word({2'd1, 2'b00, 12'hABC});
        do_reset(1'b1);
        check("R8 reset value kept");
        pulse_load();
        check("R8 shift kept over reset");

        summary();
        $finish;
    end
endmodule